// File: doc/BRIEF.md
# Four-Bit Arithmetic Logic Slice

This block is a purely combinational 4-bit arithmetic and logic slice. Two 4-bit operands, a 4-bit function select and a mode input pick one of 16 bitwise Boolean functions or one of 16 arithmetic operations. The result comes out together with a ripple carry, group propagate and generate terms for an external carry look-ahead unit, and a flag that is high when every result bit is one.

Carries use active-low polarity, and so do the group terms. A low `carry_in_n` adds one to the operation. A low `carry_out_n` reports a carry out of the most significant bit. Subtraction adds the one's complement of B, so it returns A−B−1 unless a carry is forced in. With subtraction selected and no carry in, the all-ones flag reports operand equality and `carry_out_n` reports relative magnitude.

Each bit position forms two terms, called X and Y. X is `A | (B & S[0]) | (~B & S[1])` and Y is `A & ((B & S[3]) | (~B & S[2]))`. Both the arithmetic and the logic results are defined from these two terms.

Top module: `alu_slice`

## Requirements
- R1: With `logic_mode`=1, each result bit is a function of the same bit of A and B, chosen by `fsel`: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 0, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 1, 1101 A|~B, 1110 A|B, 1111 A.
- R2: With `logic_mode`=1, `carry_in_n` has no effect on `res`.
- R3: With `logic_mode`=0, `res` = (X + Y + c) mod 16, where c is the carry in. The operand pair (X, Y) per `fsel` is: 0000 (A,0), 0001 (A|B,0), 0010 (A|~B,0), 0011 (15,0), 0100 (A,A&~B), 0101 (A|B,A&~B), 0110 (A|~B,A&~B), 0111 (15,A&~B), 1000 (A,A&B), 1001 (A|B,A&B), 1010 (A|~B,A&B), 1011 (15,A&B), 1100 (A,A), 1101 (A|B,A), 1110 (A|~B,A), 1111 (15,A).
- R4: The carry in c is 1 when `carry_in_n`=0 and 0 when `carry_in_n`=1.
- R5: `carry_out_n` is 0 exactly when X + Y + c ≥ 16. This holds in both modes.
- R6: With `fsel`=0110 and `logic_mode`=0, `res` = A−B−1 mod 16 with no carry in, and A−B mod 16 with a carry in.
- R7: With `logic_mode`=0, `fsel`=1001 gives A+B (+1 with carry in), and `fsel`=1100 gives A+A (+1 with carry in), which is A shifted one place toward the MSB.
- R8: With `logic_mode`=0, `fsel`=0011 gives 1111 without carry in and 0000 with carry in. `fsel`=1111 gives A−1 without carry in and A with carry in. `fsel`=0000 gives A without carry in and A+1 with carry in.
- R9: `res_all_ones` is 1 exactly when `res`=1111. With `fsel`=0110, `logic_mode`=0 and `carry_in_n`=1, it is 1 exactly when A = B.
- R10: With `fsel`=0110 and `logic_mode`=0: when `carry_in_n`=1, `carry_out_n` is 1 exactly when A ≤ B; when `carry_in_n`=0, `carry_out_n` is 0 exactly when A ≥ B.
- R11: `grp_prop_n` is 0 exactly when X = 1111. `grp_gen_n` is 0 exactly when X + Y ≥ 16. `carry_out_n` always equals `grp_gen_n & (grp_prop_n | carry_in_n)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B |
| fsel | input | 4 | Function select |
| logic_mode | input | 1 | 1 selects bitwise logic, 0 selects arithmetic |
| carry_in_n | input | 1 | Active-low carry into bit 0 |
| res | output | 4 | Result |
| carry_out_n | output | 1 | Active-low carry out of the MSB |
| grp_prop_n | output | 1 | Active-low group propagate |
| grp_gen_n | output | 1 | Active-low group generate |
| res_all_ones | output | 1 | High when every result bit is one |

## Verification
Every select code is driven in both modes and with both carry polarities, over all 256 operand pairs, against a model built from the function and operand tables.

- The logic-mode sweep repeats each pattern with the carry flipped, which separates a carry that leaks into a logic result from a correct one.
- The arithmetic sweep separates a wrong operand pair from a wrong carry-in polarity.
- Directed subtract patterns separate the A−B−1 and A−B results, and show where equality and the magnitude carry switch across the A = B boundary.
- Operand pairs whose sum lands exactly on 15, and just past it, separate group generate from group propagate.

// File: rtl/alu_slice_pkg.sv
// Package: shared select-bit positions and named function codes for the
// arithmetic logic slice. Assumes a 4-bit function select.
package alu_slice_pkg;
    // Select bit that lets B into the X term.
    localparam int SEL_X_B  = 0;
    // Select bit that lets ~B into the X term.
    localparam int SEL_X_NB = 1;
    // Select bit that lets A&~B into the Y term.
    localparam int SEL_Y_NB = 2;
    // Select bit that lets A&B into the Y term.
    localparam int SEL_Y_B  = 3;

    localparam logic [3:0] FN_PASS  = 4'b0000;
    localparam logic [3:0] FN_ONES  = 4'b0011;
    localparam logic [3:0] FN_SUB   = 4'b0110;
    localparam logic [3:0] FN_ADD   = 4'b1001;
    localparam logic [3:0] FN_SHIFT = 4'b1100;
    localparam logic [3:0] FN_DEC   = 4'b1111;
endpackage

// File: rtl/alu_term_cell.sv
// Module: one bit position of the slice. It forms the X term (propagate
// form) and the Y term (generate form) from one bit of A and B under the
// function select. Assumes Y can only be high when X is high.
module alu_term_cell
    import alu_slice_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic [3:0] sel,
    output logic       x_term,
    output logic       y_term
);
    // Form the two per-bit terms.
    always_comb begin
        x_term = a_bit | (b_bit & sel[SEL_X_B]) | (~b_bit & sel[SEL_X_NB]);
        y_term = a_bit & ((b_bit & sel[SEL_Y_B]) | (~b_bit & sel[SEL_Y_NB]));
    end
endmodule

// File: rtl/alu_carry_net.sv
// Module: carry network. It ripples the active-high carry through the X/Y
// terms, and separately forms the group propagate and generate terms used
// by an external look-ahead unit. Assumes y[i] implies x[i].
module alu_carry_net #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_vec,
    input  logic [WIDTH-1:0] y_vec,
    input  logic             cin,
    output logic [WIDTH-1:0] bit_carry,
    output logic             cout,
    output logic             grp_p,
    output logic             grp_g
);
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] gen_acc;

    assign chain[0] = cin;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_ripple
            // Carry into the next bit position.
            assign chain[i+1] = y_vec[i] | (x_vec[i] & chain[i]);
        end
        // Group generate accumulated from the LSB, with no carry in.
        assign gen_acc[0] = y_vec[0];
        for (i = 1; i < WIDTH; i++) begin : g_group
            assign gen_acc[i] = y_vec[i] | (x_vec[i] & gen_acc[i-1]);
        end
    endgenerate

    // Outputs: per-bit carries, ripple carry out and group terms.
    always_comb begin
        bit_carry = chain[WIDTH-1:0];
        cout      = chain[WIDTH];
        grp_p     = &x_vec;
        grp_g     = gen_acc[WIDTH-1];
    end
endmodule

// File: rtl/alu_sum_stage.sv
// Module: result stage. It combines the per-bit half sum with the incoming
// carry. Logic mode forces the carry high into every bit, which turns the
// half sum into its complement. Assumes y[i] implies x[i].
module alu_sum_stage #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_vec,
    input  logic [WIDTH-1:0] y_vec,
    input  logic [WIDTH-1:0] bit_carry,
    input  logic             logic_mode,
    output logic [WIDTH-1:0] res,
    output logic             all_ones
);
    logic [WIDTH-1:0] half_sum;
    logic [WIDTH-1:0] eff_carry;

    // Half sum, carry gated by the mode, then the result and its all-ones flag.
    always_comb begin
        half_sum  = x_vec & ~y_vec;
        eff_carry = bit_carry | {WIDTH{logic_mode}};
        res       = half_sum ^ eff_carry;
        all_ones  = &res;
    end
endmodule

// File: rtl/alu_slice.sv
// Module: top of the arithmetic logic slice. Purely combinational.
// Carry in, carry out and the group terms are active low. Assumes the
// caller forces a carry in when an exact A-B is wanted.
module alu_slice #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [3:0]       fsel,
    input  logic             logic_mode,
    input  logic             carry_in_n,
    output logic [WIDTH-1:0] res,
    output logic             carry_out_n,
    output logic             grp_prop_n,
    output logic             grp_gen_n,
    output logic             res_all_ones
);
    logic [WIDTH-1:0] x_vec;
    logic [WIDTH-1:0] y_vec;
    logic [WIDTH-1:0] bit_carry;
    logic             cout;
    logic             grp_p;
    logic             grp_g;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            alu_term_cell u_cell (
                .a_bit  (opa[i]),
                .b_bit  (opb[i]),
                .sel    (fsel),
                .x_term (x_vec[i]),
                .y_term (y_vec[i])
            );
        end
    endgenerate

    alu_carry_net #(.WIDTH(WIDTH)) u_carry (
        .x_vec     (x_vec),
        .y_vec     (y_vec),
        .cin       (~carry_in_n),
        .bit_carry (bit_carry),
        .cout      (cout),
        .grp_p     (grp_p),
        .grp_g     (grp_g)
    );

    alu_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .x_vec      (x_vec),
        .y_vec      (y_vec),
        .bit_carry  (bit_carry),
        .logic_mode (logic_mode),
        .res        (res),
        .all_ones   (res_all_ones)
    );

    // Convert the carry and group outputs to active-low polarity.
    always_comb begin
        carry_out_n = ~cout;
        grp_prop_n  = ~grp_p;
        grp_gen_n   = ~grp_g;
    end
endmodule

// File: rtl/alu_slice_chk.sv
// Module: checker for alu_slice. It relates the ports with immediate
// assertions, because the block has no clock. Bound to the top below.
module alu_slice_chk
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [3:0]       fsel,
    input logic             logic_mode,
    input logic             carry_in_n,
    input logic [WIDTH-1:0] res,
    input logic             carry_out_n,
    input logic             grp_prop_n,
    input logic             grp_gen_n,
    input logic             res_all_ones
);
    logic [WIDTH:0] diff_full;
    logic [WIDTH:0] add_full;

    // Port-level relations checked whenever an input or output changes.
    always_comb begin
        diff_full = {1'b0, opa} - {1'b0, opb} - {{WIDTH{1'b0}}, carry_in_n};
        add_full  = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, ~carry_in_n};

        // R6
        sub_result_chk: assert (logic_mode || fsel != FN_SUB ||
                                res == diff_full[WIDTH-1:0])
            else $error("subtract result mismatch");

        // R7
        add_result_chk: assert (logic_mode || fsel != FN_ADD ||
                                res == add_full[WIDTH-1:0])
            else $error("add result mismatch");

        // R1
        logic_xor_chk: assert (!logic_mode || fsel != FN_SUB ||
                               res == (opa ^ opb))
            else $error("logic xor mismatch");

        // R9
        equal_flag_chk: assert (logic_mode || fsel != FN_SUB || !carry_in_n ||
                                res_all_ones == (opa == opb))
            else $error("equality flag mismatch");

        // R10
        magnitude_chk: assert (logic_mode || fsel != FN_SUB ||
                               carry_out_n == (carry_in_n ? (opa <= opb) : (opa < opb)))
            else $error("magnitude carry mismatch");

        // R11
        group_carry_chk: assert (carry_out_n == (grp_gen_n & (grp_prop_n | carry_in_n)))
            else $error("group terms disagree with carry out");
    end
endmodule

bind alu_slice alu_slice_chk #(.WIDTH(WIDTH)) u_chk (
    .opa          (opa),
    .opb          (opb),
    .fsel         (fsel),
    .logic_mode   (logic_mode),
    .carry_in_n   (carry_in_n),
    .res          (res),
    .carry_out_n  (carry_out_n),
    .grp_prop_n   (grp_prop_n),
    .grp_gen_n    (grp_gen_n),
    .res_all_ones (res_all_ones)
);

// File: tb/alu_slice_test.sv
// Bench: directed tasks, one per scenario. The expected values come from
// the function and operand tables in the requirements.
module alu_slice_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opa = '0;
    logic [3:0] opb = '0;
    logic [3:0] fsel = '0;
    logic       logic_mode = 1'b0;
    logic       carry_in_n = 1'b1;
    logic [3:0] res;
    logic       carry_out_n;
    logic       grp_prop_n;
    logic       grp_gen_n;
    logic       res_all_ones;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    alu_slice uut (
        .opa          (opa),
        .opb          (opb),
        .fsel         (fsel),
        .logic_mode   (logic_mode),
        .carry_in_n   (carry_in_n),
        .res          (res),
        .carry_out_n  (carry_out_n),
        .grp_prop_n   (grp_prop_n),
        .grp_gen_n    (grp_gen_n),
        .res_all_ones (res_all_ones)
    );

    // Logic-mode function table (R1).
    function automatic logic [3:0] logic_ref(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
        case (s)
            4'h0: return ~a;
            4'h1: return ~(a | b);
            4'h2: return ~a & b;
            4'h3: return 4'h0;
            4'h4: return ~(a & b);
            4'h5: return ~b;
            4'h6: return a ^ b;
            4'h7: return a & ~b;
            4'h8: return ~a | b;
            4'h9: return ~(a ^ b);
            4'hA: return b;
            4'hB: return a & b;
            4'hC: return 4'hF;
            4'hD: return a | ~b;
            4'hE: return a | b;
            default: return a;
        endcase
    endfunction

    // Arithmetic operand pair table (R3).
    task automatic operand_ref(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b,
                               output int x, output int y);
        logic [3:0] xv;
        logic [3:0] yv;
        case (s[1:0])
            2'b00: xv = a;
            2'b01: xv = a | b;
            2'b10: xv = a | ~b;
            default: xv = 4'hF;
        endcase
        case (s[3:2])
            2'b00: yv = 4'h0;
            2'b01: yv = a & ~b;
            2'b10: yv = a & b;
            default: yv = a;
        endcase
        x = int'(xv);
        y = int'(yv);
    endtask

    task automatic expect_val(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (fsel=%b m=%b cn=%b a=%0d b=%0d)",
                     tag, what, act, exp, fsel, logic_mode, carry_in_n, opa, opb);
        end
    endtask

    // Drive one vector and wait until mid-cycle, when the outputs have settled.
    task automatic drive(input logic [3:0] s, input logic m, input logic cn,
                         input logic [3:0] a, input logic [3:0] b);
        @(posedge clk);
        fsel = s; logic_mode = m; carry_in_n = cn; opa = a; opb = b;
        @(negedge clk);
    endtask

    // Full model comparison of all outputs for the current inputs.
    task automatic check_model(input string tag);
        int x, y, c, sum;
        int f_exp;
        operand_ref(fsel, opa, opb, x, y);
        c   = carry_in_n ? 0 : 1;          // R4
        sum = x + y + c;
        f_exp = logic_mode ? int'(logic_ref(fsel, opa, opb)) : (sum % 16);
        expect_val(tag, "res", int'(res), f_exp);
        expect_val(tag, "carry_out_n R5", int'(carry_out_n), (sum >= 16) ? 0 : 1);
        expect_val(tag, "grp_prop_n R11", int'(grp_prop_n), (x == 15) ? 0 : 1);
        expect_val(tag, "grp_gen_n R11", int'(grp_gen_n), (x + y >= 16) ? 0 : 1);
        expect_val(tag, "all_ones R9", int'(res_all_ones), (f_exp == 15) ? 1 : 0);
    endtask

    task automatic t_idle();
        drive(4'h0, 1'b0, 1'b1, 4'h0, 4'h0);
        expect_val("R3", "idle res", int'(res), 0);
        expect_val("R5", "idle carry_out_n", int'(carry_out_n), 1);
        expect_val("R11", "idle grp_prop_n", int'(grp_prop_n), 1);
        expect_val("R11", "idle grp_gen_n", int'(grp_gen_n), 1);
    endtask

    task automatic t_logic_all();
        for (int s = 0; s < 16; s++)
            for (int v = 0; v < 256; v++) begin
                logic [3:0] r_hi;
                drive(4'(s), 1'b1, 1'b1, 4'(v), 4'(v >> 4));
                check_model("R1");
                r_hi = res;
                drive(4'(s), 1'b1, 1'b0, 4'(v), 4'(v >> 4));
                check_model("R1");
                expect_val("R2", "cn has no effect", int'(res), int'(r_hi));
            end
    endtask

    task automatic t_arith_all();
        for (int s = 0; s < 16; s++)
            for (int cn = 0; cn < 2; cn++)
                for (int v = 0; v < 256; v++) begin
                    drive(4'(s), 1'b0, cn[0], 4'(v), 4'(v >> 4));
                    check_model("R3");
                end
    endtask

    task automatic t_subtract();
        for (int v = 0; v < 256; v++) begin
            int a = v % 16;
            int b = v / 16;
            drive(4'b0110, 1'b0, 1'b1, 4'(a), 4'(b));
            expect_val("R6", "A-B-1", int'(res), (a - b - 1 + 32) % 16);
            drive(4'b0110, 1'b0, 1'b0, 4'(a), 4'(b));
            expect_val("R6", "A-B", int'(res), (a - b + 16) % 16);
        end
    endtask

    task automatic t_add_shift();
        for (int v = 0; v < 256; v++) begin
            int a = v % 16;
            int b = v / 16;
            drive(4'b1001, 1'b0, 1'b1, 4'(a), 4'(b));
            expect_val("R7", "A+B", int'(res), (a + b) % 16);
            drive(4'b1001, 1'b0, 1'b0, 4'(a), 4'(b));
            expect_val("R7", "A+B+1", int'(res), (a + b + 1) % 16);
            drive(4'b1100, 1'b0, 1'b1, 4'(a), 4'(b));
            expect_val("R7", "shift", int'(res), (a * 2) % 16);
            drive(4'b1100, 1'b0, 1'b0, 4'(a), 4'(b));
            expect_val("R7", "shift+1", int'(res), (a * 2 + 1) % 16);
        end
    endtask

    task automatic t_const();
        for (int a = 0; a < 16; a++) begin
            drive(4'b0011, 1'b0, 1'b1, 4'(a), 4'(15 - a));
            expect_val("R8", "minus one", int'(res), 15);
            drive(4'b0011, 1'b0, 1'b0, 4'(a), 4'(15 - a));
            expect_val("R8", "zero", int'(res), 0);
            drive(4'b1111, 1'b0, 1'b1, 4'(a), 4'(a));
            expect_val("R8", "A-1", int'(res), (a + 15) % 16);
            drive(4'b1111, 1'b0, 1'b0, 4'(a), 4'(a));
            expect_val("R8", "A", int'(res), a);
            drive(4'b0000, 1'b0, 1'b1, 4'(a), 4'(3));
            expect_val("R8", "pass A", int'(res), a);
            drive(4'b0000, 1'b0, 1'b0, 4'(a), 4'(3));
            expect_val("R8", "A+1", int'(res), (a + 1) % 16);
        end
    endtask

    task automatic t_equal();
        for (int v = 0; v < 256; v++) begin
            drive(4'b0110, 1'b0, 1'b1, 4'(v), 4'(v >> 4));
            expect_val("R9", "equality", int'(res_all_ones), ((v % 16) == (v / 16)) ? 1 : 0);
        end
    endtask

    task automatic t_magnitude();
        for (int v = 0; v < 256; v++) begin
            int a = v % 16;
            int b = v / 16;
            drive(4'b0110, 1'b0, 1'b1, 4'(a), 4'(b));
            expect_val("R10", "cn=1 A<=B", int'(carry_out_n), (a <= b) ? 1 : 0);
            drive(4'b0110, 1'b0, 1'b0, 4'(a), 4'(b));
            expect_val("R10", "cn=0 A>=B", int'(carry_out_n), (a >= b) ? 0 : 1);
        end
    endtask

    task automatic t_group();
        // fsel 1001: X=A|B, Y=A&B. a=5,b=10 gives X=15,Y=0 (propagate only).
        drive(4'b1001, 1'b0, 1'b1, 4'd5, 4'd10);
        expect_val("R11", "prop only P", int'(grp_prop_n), 0);
        expect_val("R11", "prop only G", int'(grp_gen_n), 1);
        expect_val("R11", "prop only cout", int'(carry_out_n), 1);
        drive(4'b1001, 1'b0, 1'b0, 4'd5, 4'd10);
        expect_val("R11", "prop with cin cout", int'(carry_out_n), 0);
        // a=8,b=8: X=8,Y=8, sum 16 -> generate without full propagate.
        drive(4'b1001, 1'b0, 1'b1, 4'd8, 4'd8);
        expect_val("R11", "gen only P", int'(grp_prop_n), 1);
        expect_val("R11", "gen only G", int'(grp_gen_n), 0);
        expect_val("R11", "gen only cout", int'(carry_out_n), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_logic_all();
        t_arith_all();
        t_subtract();
        t_add_shift();
        t_const();
        t_equal();
        t_magnitude();
        t_group();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule